// File: doc/BRIEF.md
# Serial Bit-Clock Source Detector

This block decides whether an audio serial port is being fed a bit clock from outside or must fall back to its own internally generated bit clock. It watches the bit-clock pin and the frame-clock pin in the system clock domain, after synchronizing both, and keeps a single mode flag. The flag is set by a burst of bit-clock activity confined to one frame half. It is cleared only after whole frame periods go by with no bit-clock activity at all. This asymmetry stops a few stray edges from switching the port, and stops a short gap from dropping it back.

While the flag shows internal mode, frame halves are taken from an internally generated frame reference, which is synchronous to the system clock. While it shows external mode, frame halves and periods are taken from the synchronized frame-clock pin. The number of bit-clock rising edges counted in the current frame half is presented as a debug value.

Top module: `sclk_mode_detect`

## Requirements
- R1: After reset the mode output is 0 (internal) and the edge count output is 0.
- R2: The bit-clock and frame-clock pins each pass through two synchronizer flops before edge detection. A pin value first presented before system clock edge k acts on the state at edge k+2. A change of the internal frame reference acts at edge k.
- R3: Only low-to-high transitions of the bit clock are counted. Each one raises the edge count by one, and with no transition the count holds.
- R4: Every transition of the active frame reference (rising or falling) ends a frame half. The count then restarts: to 1 if a bit-clock rise falls in the same cycle, otherwise to 0.
- R5: The edge count saturates at ENTRY_EDGES (default 16) and never exceeds it.
- R6: In internal mode, the mode output becomes 1 at the very clock edge at which the count reaches ENTRY_EDGES within one frame half. This applies whether that half is high or low. Fewer edges per half never switch the mode.
- R7: In internal mode the frame halves come from the internal frame reference, and frame-clock pin activity has no effect. In external mode they come from the synchronized frame-clock pin, and the internal reference has no effect.
- R8: In external mode the mode output returns to 0 at the edge where the synchronized frame-clock pin rises for the third time since the last bit-clock rise. That is the rise that closes EXIT_PERIODS (default 2) full rise-to-rise periods with no bit-clock rise.
- R9: Any bit-clock rise restarts the idle measurement, including one in the same cycle as a frame-clock rise.
- R10: The mode output changes on no other clock edge than those given in R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Bit-clock pin, asynchronous |
| lrck_i | input | 1 | Frame-clock pin, asynchronous |
| lrck_int_i | input | 1 | Internally generated frame reference, synchronous to clk_i |
| ext_mode_o | output | 1 | 1 = external bit clock in use, 0 = internal |
| edge_cnt_o | output | $clog2(ENTRY_EDGES+1) | Bit-clock rising edges seen in the current frame half |

## Verification
The bench builds the block with ENTRY_EDGES=16 and EXIT_PERIODS=2. Frame halves of a few dozen system cycles therefore hold enough bit-clock pulses to cross the entry threshold, to fall one short of it, and to saturate the count. With two exit periods, a one-and-a-half-period gap that is then broken by a single pulse can be told apart from a true loss of clock within a few hundred cycles. Bit-clock rises that land in the same cycle as frame-clock edges are driven on purpose, so both tie-break rules are exercised.

// File: rtl/scm_pkg.sv
`timescale 1ns/1ps
package scm_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } sclk_src_e;
endpackage

// File: rtl/sync_chain.sv
`timescale 1ns/1ps
module sync_chain #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/edge_det.sv
`timescale 1ns/1ps
module edge_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] tog_o
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= '0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;
  assign tog_o  = d_i ^ d_q;
endmodule

// File: rtl/phase_edge_counter.sv
`timescale 1ns/1ps
module phase_edge_counter #(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_tog_i,
  input  logic          bit_rise_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (frame_tog_i)                           cnt_d = bit_rise_i ? ONE : '0;
    else if (bit_rise_i && (cnt_q != CMAX))    cnt_d = cnt_q + ONE;
  end

  // threshold crossed on this edge (not merely sitting at it)
  assign hit_o = bit_rise_i && (cnt_d == CMAX) && (frame_tog_i || (cnt_q != CMAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_cnt_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_tog_i && !bit_rise_i) |=> $stable(cnt_q));
  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_tog_i && bit_rise_i && (cnt_q < CMAX)) |=> (cnt_q == $past(cnt_q) + ONE));
  p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tog_i |=> (cnt_q <= ONE));
endmodule

// File: rtl/idle_period_counter.sv
`timescale 1ns/1ps
module idle_period_counter #(
  parameter int unsigned PERIODS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_rise_i,
  input  logic bit_rise_i,
  output logic exit_o
);
  // counts frame rises since the last bit-clock rise; first rise opens a period
  localparam int unsigned IMAX = PERIODS + 1;
  localparam int unsigned IW   = $clog2(IMAX + 1);
  localparam logic [IW-1:0] LAST = IW'(PERIODS);
  localparam logic [IW-1:0] TOP  = IW'(IMAX);

  logic [IW-1:0] idle_q, idle_d;

  always_comb begin
    idle_d = idle_q;
    if (bit_rise_i)                         idle_d = '0;
    else if (frame_rise_i && idle_q != TOP) idle_d = idle_q + IW'(1);
  end

  assign exit_o = frame_rise_i && !bit_rise_i && (idle_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= '0;
    else         idle_q <= idle_d;
  end

  p_idle_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q <= TOP);
  p_bit_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_rise_i |=> (idle_q == '0));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_rise_i && !frame_rise_i) |=> $stable(idle_q));
endmodule

// File: rtl/sclk_mode_detect.sv
`timescale 1ns/1ps
module sclk_mode_detect
  import scm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned ENTRY_EDGES  = 16,
  parameter int unsigned EXIT_PERIODS = 2,
  localparam int unsigned CNT_W       = $clog2(ENTRY_EDGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             lrck_i,
  input  logic             lrck_int_i,
  output logic             ext_mode_o,
  output logic [CNT_W-1:0] edge_cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(ENTRY_EDGES);

  logic       sclk_s, lrck_s, sclk_d_q, sclk_rise;
  logic [1:0] fr_rise, fr_tog;   // [1] frame pin, [0] internal reference
  logic       frame_tog, frame_rise;
  logic       entry_hit, exit_hit;
  sclk_src_e  mode_q;

  sync_chain #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, lrck_i}),
    .q_o   ({sclk_s, lrck_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_d_q;

  edge_det #(.W(2)) u_frame_edges (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lrck_s, lrck_int_i}),
    .rise_o(fr_rise),
    .tog_o (fr_tog)
  );

  // frame reference follows the current clock source
  assign frame_tog  = (mode_q == SRC_EXT) ? fr_tog[1]  : fr_tog[0];
  assign frame_rise = (mode_q == SRC_EXT) ? fr_rise[1] : fr_rise[0];

  phase_edge_counter #(.LIMIT(ENTRY_EDGES), .CW(CNT_W)) u_phase_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_tog_i(frame_tog),
    .bit_rise_i (sclk_rise),
    .cnt_o      (edge_cnt_o),
    .hit_o      (entry_hit)
  );

  idle_period_counter #(.PERIODS(EXIT_PERIODS)) u_idle_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_rise_i(frame_rise),
    .bit_rise_i  (sclk_rise),
    .exit_o      (exit_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               mode_q <= SRC_INT;
    else if (mode_q == SRC_INT && entry_hit)   mode_q <= SRC_EXT;
    else if (mode_q == SRC_EXT && exit_hit)    mode_q <= SRC_INT;
  end

  assign ext_mode_o = (mode_q == SRC_EXT);

  p_enter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SRC_INT && entry_hit) |=> (mode_q == SRC_EXT));
  p_enter_at_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q == SRC_EXT) |-> (edge_cnt_o == CMAX));
  p_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SRC_EXT && exit_hit) |=> (mode_q == SRC_INT));
  p_mode_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!entry_hit && !exit_hit) |=> $stable(mode_q));
endmodule

// File: tb/sclk_mode_detect_test.sv
`timescale 1ns/1ps
module sclk_mode_detect_test;
  localparam int ENTRY = 16;
  localparam int EXIT  = 2;
  localparam int CW    = $clog2(ENTRY + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0;
  logic sclk = 1'b0, lrck = 1'b0, lint = 1'b0;
  logic          ext_mode;
  logic [CW-1:0] ecnt;

  sclk_mode_detect #(.SYNC_STAGES(2), .ENTRY_EDGES(ENTRY), .EXIT_PERIODS(EXIT)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk),
    .lrck_i    (lrck),
    .lrck_int_i(lint),
    .ext_mode_o(ext_mode),
    .edge_cnt_o(ecnt)
  );

  int total = 0;
  int bad   = 0;

  // scoreboard
  bit    q_mode[$];
  int    q_cnt[$];
  string q_tag[$];
  string tag = "R1";

  // requirement-level model state
  logic [2:0] sh = '0;   // sh[0]=s[t-1], sh[1]=s[t-2], sh[2]=s[t-3]
  logic [2:0] lh = '0;
  logic       ip = 1'b0;
  bit         m_mode = 1'b0;
  int         m_cnt  = 0;
  int         m_idle = 0;

  task automatic step(input logic s, input logic l, input logic i);
    bit srise, lrise, ltog, irise, itog, fedge, frise, entry, leave;
    int old_cnt, old_idle;
    @(negedge clk);
    sclk = s; lrck = l; lint = i;
    // R2: pins act two edges late, internal reference at once
    srise = sh[1] && !sh[2];
    lrise = lh[1] && !lh[2];
    ltog  = lh[1] != lh[2];
    irise = i && !ip;
    itog  = i != ip;
    fedge = m_mode ? ltog  : itog;   // R7
    frise = m_mode ? lrise : irise;
    old_cnt  = m_cnt;
    old_idle = m_idle;
    if (fedge)                        m_cnt = srise ? 1 : 0;   // R4
    else if (srise && m_cnt < ENTRY)  m_cnt = m_cnt + 1;       // R3 R5
    entry = srise && !fedge && (old_cnt == ENTRY - 1);         // R6
    if (srise)                          m_idle = 0;            // R9
    else if (frise && m_idle < EXIT+1)  m_idle = m_idle + 1;
    leave = frise && !srise && (old_idle == EXIT);             // R8
    if (!m_mode && entry)     m_mode = 1'b1;
    else if (m_mode && leave) m_mode = 1'b0;
    sh = {sh[1:0], s};
    lh = {lh[1:0], l};
    ip = i;
    q_mode.push_back(m_mode);
    q_cnt.push_back(m_cnt);
    q_tag.push_back(tag);
  endtask

  // sclk_half=0: bit clock held low; l_half/i_half=0: held
  task automatic run(input int n, input int sclk_half, input int l_half, input int i_half);
    logic l_v, i_v, s_v;
    l_v = lrck;
    i_v = lint;
    for (int t = 0; t < n; t++) begin
      if (l_half > 0 && t > 0 && (t % l_half) == 0) l_v = ~l_v;
      if (i_half > 0 && t > 0 && (t % i_half) == 0) i_v = ~i_v;
      s_v = (sclk_half > 0) ? logic'(((t / sclk_half) % 2) == 0) : 1'b0;
      step(s_v, l_v, i_v);
    end
  endtask

  // monitor
  initial begin
    bit    em;
    int    ec;
    string et;
    forever begin
      @(posedge clk);
      #1;
      if (q_mode.size() > 0) begin
        em = q_mode.pop_front();
        ec = q_cnt.pop_front();
        et = q_tag.pop_front();
        total++;
        if (ext_mode !== em || int'(ecnt) != ec) begin
          bad++;
          $display("FAIL %s: mode=%0d cnt=%0d expected mode=%0d cnt=%0d at %0t",
                   et, ext_mode, ecnt, em, ec, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL R10: watchdog expired, actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;  // R1 reset state
    if (ext_mode !== 1'b0 || ecnt !== '0) begin
      bad++;
      $display("FAIL R1: mode=%0d cnt=%0d expected mode=0 cnt=0", ext_mode, ecnt);
    end
    rst_ni = 1'b1;

    tag = "R1";        run(4, 0, 0, 0);
    tag = "R3 R7";     run(40, 0, 5, 8);           // frame activity, no bit clock
    tag = "R4 R6";     step(0, lrck, 1'b0);
                       run(60, 2, 0, 0);           // 15 rises, one short
                       run(3, 0, 0, 0);
                       step(0, lrck, 1'b1);        // half ends, count cleared
                       run(4, 0, 0, 0);
    tag = "R4";        run(32, 2, 0, 0);           // split burst across halves
                       step(0, lrck, 1'b0);
                       run(32, 2, 0, 0);
                       step(0, lrck, 1'b1);
                       run(4, 0, 0, 0);
    tag = "R6 R7 R2";  run(64, 2, 6, 0);           // 16 rises in high half, pin toggles ignored
                       run(8, 0, 0, 0);
    tag = "R5 R7";     run(240, 2, 40, 12);        // saturation, internal ref ignored
    tag = "R8 R9";     run(30, 0, 10, 0);          // 1.5 idle periods
                       run(4, 2, 10, 0);           // one rise restarts
                       run(70, 0, 10, 0);          // true loss of clock
    tag = "R6 R10";    step(0, lrck, 1'b1);
                       step(0, lrck, 1'b0);
                       run(68, 2, 0, 0);           // entry in low half
    tag = "R4 R9";     run(64, 2, 4, 0);           // rises coincide with frame edges
    tag = "R8 R10";    run(24, 0, 4, 0);
                       run(10, 0, 0, 6);

    repeat (4) @(posedge clk);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule